// File: doc/BRIEF.md
# Edge-Aligned PWM Generator with Latched Trip

This block generates one edge-aligned PWM waveform from an up-counting time base. A prescaler built from two multiplied divide factors sets the rate of the time base. The counter runs from zero up to the active period value and then wraps. The output rises when the counter enters zero and falls when it reaches the active compare value. The period and compare values are written into holding registers, which move into the active registers only when the counter wraps. A frame therefore never sees a half-updated setting.

After the action stage, the output passes through a dead-band stage. This stage holds back the rising edge by a programmable number of clocks and lets the falling edge through at once. A trip input has an enable. When it fires, it forces the output low and latches a flag that stays set until an explicit clear. A one-clock sync pulse marks the start of each frame, so a slope or ramp generator elsewhere can restart in step with the PWM.

Top module: `pwm_trip_gen`

## Requirements
- R1: The counter advances once per time-base tick and runs from 0 up to the active period P. It then returns to 0, so one frame lasts (P+1)·L clocks, where L is the prescale ratio.
- R2: The prescale ratio L is the product of two factor inputs. A factor value of 0 counts as 1, and factors 1 and 1 give one tick per clock.
- R3: With a dead-band of 0 and a compare value C where 0 < C ≤ P, the output is high for exactly C·L clocks. The high time starts the clock after the sync pulse.
- R4: When C = 0, the output stays low for the whole frame, because the clear action wins over the set action when both fall on the same count. When C > P, the output is never cleared and stays high.
- R5: A write to the period or compare register does not change the frame in progress. It takes effect at the next wrap to zero.
- R6: The dead-band value D delays each rising edge by D clocks, and falling edges are not delayed. A high pulse of H clocks therefore appears as max(H−D, 0) clocks, so a pulse shorter than D gives no output at all. A write to D takes effect at once.
- R7: The sync output is high for exactly one clock, the first clock of each frame, even when the prescaler is dividing.
- R8: When trip_en is high and trip_in is sampled high, the output goes low in the same clock. trip_flag is set at the next edge.
- R9: trip_flag stays set, and the output stays low, until trip_clr is asserted. If a trip and a clear arrive in the same clock, the trip wins.
- R10: While trip_en is low, trip_in has no effect on either the output or the flag.
- R11: Reset drives the output low and clears the flag. It loads the period and compare registers with their parameter defaults (99 and 0), so the first frame is 100 clocks long and has no high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_a | input | PSW | First prescale factor (0 counts as 1) |
| div_b | input | PSW | Second prescale factor (0 counts as 1) |
| prd_wr | input | 1 | Write strobe for the period holding register |
| prd_wdata | input | CW | Period value to write |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | CW | Compare value to write |
| db_wr | input | 1 | Write strobe for the rising-edge delay |
| db_wdata | input | DW | Rising-edge delay in clocks |
| trip_en | input | 1 | Enables the trip input |
| trip_in | input | 1 | Trip request |
| trip_clr | input | 1 | Clears the latched trip |
| pwm_out | output | 1 | PWM output after dead-band and trip gating |
| sync_out | output | 1 | One-clock pulse at the start of each frame |
| trip_flag | output | 1 | Latched trip indication |

## Verification
The checker watches several properties on every clock. The counter must never pass the active period, and the sync pulse must come only at count zero. The active period and compare values may change only at a wrap. The output may be high only while the raw action output is high and no trip is latched. The trip flag must set after an enabled trip, must hold until cleared, and must stay clear while the trip is disabled. Some properties span a whole frame and can only be shown by the bench's scenarios: frame length under different prescale ratios, exact high-time counts including the dead-band shortening, the saturation cases at C = 0 and C > P, and the deferred effect of a mid-frame write.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

  // A prescale factor of zero is read as one.
  function automatic int unsigned div_factor(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Clocks per time-base tick.
  function automatic int unsigned div_limit(input int unsigned a, input int unsigned b);
    return div_factor(a) * div_factor(b);
  endfunction

  // The output may rise once the raw signal has been high for dly clocks.
  function automatic logic rise_ready(input int unsigned held, input int unsigned dly);
    return held >= dly;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_trip_pkg::*;
#(
  parameter int CW       = 16,
  parameter int PSW      = 3,
  parameter int PRD_INIT = 99,
  parameter int CMP_INIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PSW-1:0] div_a,
  input  logic [PSW-1:0] div_b,
  input  logic          prd_wr,
  input  logic [CW-1:0] prd_wdata,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] prd_act,
  output logic [CW-1:0] cmp_act,
  output logic          zero_evt,
  output logic          cmp_evt,
  output logic          wrap_evt
);
  localparam int PCW = 2 * PSW;

  logic [PCW-1:0] pre_cnt;
  logic [PCW-1:0] pre_lim;
  logic           tick;
  logic           step;     // first clock in which cnt holds a new value
  logic [CW-1:0]  prd_sh;
  logic [CW-1:0]  cmp_sh;

  assign pre_lim  = PCW'(div_limit(32'(div_a), 32'(div_b)));
  assign tick     = (pre_cnt >= pre_lim - PCW'(1));
  assign wrap_evt = tick && (cnt == prd_act);
  assign zero_evt = step && (cnt == '0);
  assign cmp_evt  = step && (cnt == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      step    <= 1'b1;
      cnt     <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + PCW'(1);
      step    <= tick;
      if (tick) cnt <= wrap_evt ? '0 : cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh  <= CW'(PRD_INIT);
      cmp_sh  <= CW'(CMP_INIT);
      prd_act <= CW'(PRD_INIT);
      cmp_act <= CW'(CMP_INIT);
    end else begin
      if (prd_wr) prd_sh <= prd_wdata;
      if (cmp_wr) cmp_sh <= cmp_wdata;
      if (wrap_evt) begin
        prd_act <= prd_sh;
        cmp_act <= cmp_sh;
      end
    end
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic cmp_evt,
  output logic raw_pwm
);
  // Clear on compare wins over set on zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        raw_pwm <= 1'b0;
    else if (cmp_evt)  raw_pwm <= 1'b0;
    else if (zero_evt) raw_pwm <= 1'b1;
  end
endmodule

// File: rtl/pwm_rise_delay.sv
module pwm_rise_delay
  import pwm_trip_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          db_wr,
  input  logic [DW-1:0] db_wdata,
  input  logic          raw_in,
  output logic          dly_out
);
  logic [DW-1:0] db_q;
  logic [DW-1:0] held;   // clocks raw_in has been high, saturating

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q <= '0;
      held <= '0;
    end else begin
      if (db_wr) db_q <= db_wdata;
      if (!raw_in)          held <= '0;
      else if (held != '1) held <= held + DW'(1);
    end
  end

  assign dly_out = raw_in && rise_ready(32'(held), 32'(db_q));
endmodule

// File: rtl/pwm_trip_latch.sv
module pwm_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_en,
  input  logic trip_in,
  input  logic trip_clr,
  output logic trip_q,
  output logic force_low
);
  logic trip_now;
  assign trip_now  = trip_en && trip_in;
  assign force_low = trip_q || trip_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trip_q <= 1'b0;
    else if (trip_now) trip_q <= 1'b1;
    else if (trip_clr) trip_q <= 1'b0;
  end
endmodule

// File: rtl/pwm_trip_gen.sv
module pwm_trip_gen #(
  parameter int CW       = 16,
  parameter int DW       = 8,
  parameter int PSW      = 3,
  parameter int PRD_INIT = 99,
  parameter int CMP_INIT = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PSW-1:0] div_a,
  input  logic [PSW-1:0] div_b,
  input  logic           prd_wr,
  input  logic [CW-1:0]  prd_wdata,
  input  logic           cmp_wr,
  input  logic [CW-1:0]  cmp_wdata,
  input  logic           db_wr,
  input  logic [DW-1:0]  db_wdata,
  input  logic           trip_en,
  input  logic           trip_in,
  input  logic           trip_clr,
  output logic           pwm_out,
  output logic           sync_out,
  output logic           trip_flag
);
  logic [CW-1:0] tb_cnt;
  logic [CW-1:0] prd_act;
  logic [CW-1:0] cmpb_act;
  logic          zero_evt;
  logic          cmpb_evt;
  logic          tb_wrap;
  logic          raw_pwm;
  logic          dly_pwm;
  logic          trip_q;
  logic          trip_force;

  pwm_timebase #(
    .CW(CW), .PSW(PSW), .PRD_INIT(PRD_INIT), .CMP_INIT(CMP_INIT)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .div_a(div_a), .div_b(div_b),
    .prd_wr(prd_wr), .prd_wdata(prd_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cnt(tb_cnt), .prd_act(prd_act), .cmp_act(cmpb_act),
    .zero_evt(zero_evt), .cmp_evt(cmpb_evt), .wrap_evt(tb_wrap)
  );

  pwm_action u_aq (
    .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .cmp_evt(cmpb_evt),
    .raw_pwm(raw_pwm)
  );

  pwm_rise_delay #(.DW(DW)) u_db (
    .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_wdata(db_wdata),
    .raw_in(raw_pwm), .dly_out(dly_pwm)
  );

  pwm_trip_latch u_trip (
    .clk(clk), .rst_n(rst_n), .trip_en(trip_en), .trip_in(trip_in),
    .trip_clr(trip_clr), .trip_q(trip_q), .force_low(trip_force)
  );

  assign pwm_out   = dly_pwm && !trip_force;
  assign sync_out  = zero_evt;
  assign trip_flag = trip_q;
endmodule

// File: rtl/pwm_trip_chk.sv
module pwm_trip_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trip_en,
  input logic          trip_in,
  input logic          trip_clr,
  input logic          trip_flag,
  input logic          pwm_out,
  input logic          sync_out,
  input logic          raw_pwm,
  input logic [CW-1:0] tb_cnt,
  input logic [CW-1:0] prd_act,
  input logic [CW-1:0] cmpb_act,
  input logic          tb_wrap
);
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tb_cnt <= prd_act);

  assert_active_only_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_wrap |=> ($stable(prd_act) && $stable(cmpb_act)));

  assert_fall_not_delayed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_pwm |-> !pwm_out);

  assert_sync_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> (tb_cnt == '0));

  assert_trip_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_en && trip_in) |=> trip_flag);

  assert_trip_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag || (trip_en && trip_in)) |-> !pwm_out);

  assert_trip_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag && !trip_clr) |=> trip_flag);

  assert_trip_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_flag && !trip_en) |=> !trip_flag);
endmodule

bind pwm_trip_gen pwm_trip_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trip_en(trip_en), .trip_in(trip_in),
  .trip_clr(trip_clr), .trip_flag(trip_flag), .pwm_out(pwm_out),
  .sync_out(sync_out), .raw_pwm(raw_pwm), .tb_cnt(tb_cnt),
  .prd_act(prd_act), .cmpb_act(cmpb_act), .tb_wrap(tb_wrap)
);

// File: tb/test_pwm_trip_gen.sv
module test_pwm_trip_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  div_a = 3'd1, div_b = 3'd1;
  logic        prd_wr = 1'b0, cmp_wr = 1'b0, db_wr = 1'b0;
  logic [15:0] prd_wdata = '0, cmp_wdata = '0;
  logic [7:0]  db_wdata = '0;
  logic        trip_en = 1'b0, trip_in = 1'b0, trip_clr = 1'b0;
  logic        pwm_out, sync_out, trip_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_trip_gen i_pwm_trip_gen (
    .clk(clk), .rst_n(rst_n), .div_a(div_a), .div_b(div_b),
    .prd_wr(prd_wr), .prd_wdata(prd_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .db_wr(db_wr), .db_wdata(db_wdata), .trip_en(trip_en), .trip_in(trip_in),
    .trip_clr(trip_clr), .pwm_out(pwm_out), .sync_out(sync_out), .trip_flag(trip_flag)
  );

  typedef struct packed {
    logic [15:0] prd;
    logic [15:0] cmp;
    logic [7:0]  dbv;
    logic [2:0]  fa;
    logic [2:0]  fb;
    logic [15:0] exp_len;
    logic [15:0] exp_high;
  } vec_t;

  // expected length = (P+1)*L, expected high = P<C ? length : max(C*L - D, 0)
  localparam vec_t VEC [9] = '{
    '{16'd9,  16'd4,  8'd0, 3'd1, 3'd1, 16'd10, 16'd4},   // R1 R3 basic
    '{16'd9,  16'd4,  8'd2, 3'd1, 3'd1, 16'd10, 16'd2},   // R6 rise delayed
    '{16'd9,  16'd2,  8'd3, 3'd1, 3'd1, 16'd10, 16'd0},   // R6 pulse shorter than delay
    '{16'd9,  16'd0,  8'd0, 3'd1, 3'd1, 16'd10, 16'd0},   // R4 compare zero
    '{16'd9,  16'd12, 8'd1, 3'd1, 3'd1, 16'd10, 16'd10},  // R4 compare above period
    '{16'd9,  16'd9,  8'd0, 3'd1, 3'd1, 16'd10, 16'd9},   // R3 compare equals period
    '{16'd4,  16'd2,  8'd1, 3'd2, 3'd3, 16'd30, 16'd11},  // R2 divide by 6
    '{16'd3,  16'd1,  8'd0, 3'd0, 3'd2, 16'd8,  16'd2},   // R2 zero factor reads as one
    '{16'd0,  16'd1,  8'd0, 3'd1, 3'd1, 16'd1,  16'd1}    // R1 single-count frame
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!sync_out);
  endtask

  // Count clocks and high clocks from the current sync up to and including the next one.
  task automatic frame(output int n, output int h);
    n = 0; h = 0;
    do begin
      @(negedge clk);
      n++;
      if (pwm_out) h++;
    end while (!sync_out);
  endtask

  task automatic configure(input vec_t v);
    @(negedge clk);
    prd_wr = 1'b1; prd_wdata = v.prd;
    cmp_wr = 1'b1; cmp_wdata = v.cmp;
    db_wr  = 1'b1; db_wdata  = v.dbv;
    div_a  = v.fa; div_b = v.fb;
    @(negedge clk);
    prd_wr = 1'b0; cmp_wr = 1'b0; db_wr = 1'b0;
    repeat (3) wait_sync();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n, h;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 pwm_out in reset", pwm_out, 0);
    chk("R11 trip_flag in reset", trip_flag, 0);
    rst_n = 1'b1;
    wait_sync();
    frame(n, h);
    chk("R11 default frame length", n, 100);
    chk("R11 default high time", h, 0);

    // Table of frame shapes
    for (int i = 0; i < 9; i++) begin
      configure(VEC[i]);
      frame(n, h);
      chk($sformatf("R1 frame length vec %0d", i), n, VEC[i].exp_len);
      chk($sformatf("R3 high time vec %0d", i), h, VEC[i].exp_high);
    end

    // R7: sync lasts one clock while dividing by 3
    configure('{16'd4, 16'd2, 8'd0, 3'd3, 3'd1, 16'd0, 16'd0});
    wait_sync();
    @(negedge clk);
    chk("R7 sync one clock", sync_out, 0);

    // R5: writes mid-frame apply from the next frame
    configure('{16'd15, 16'd8, 8'd0, 3'd1, 3'd1, 16'd0, 16'd0});
    wait_sync();
    prd_wr = 1'b1; prd_wdata = 16'd7;
    cmp_wr = 1'b1; cmp_wdata = 16'd3;
    frame(n, h);
    prd_wr = 1'b0; cmp_wr = 1'b0;
    chk("R5 current frame length kept", n, 16);
    chk("R5 current high kept", h, 8);
    frame(n, h);
    chk("R5 next frame length", n, 8);
    chk("R5 next high", h, 3);

    // Trip tests on P=9, C=9
    configure('{16'd9, 16'd9, 8'd0, 3'd1, 3'd1, 16'd0, 16'd0});
    // R10: disabled trip ignored
    trip_en = 1'b0; trip_in = 1'b1;
    wait_sync();
    frame(n, h);
    chk("R10 high with trip disabled", h, 9);
    chk("R10 flag with trip disabled", trip_flag, 0);
    trip_in = 1'b0;

    // R8: enabled trip forces low at once
    trip_en = 1'b1;
    wait_sync();
    repeat (2) @(negedge clk);
    chk("R8 output high before trip", pwm_out, 1);
    trip_in = 1'b1;
    #1;
    chk("R8 output low same clock", pwm_out, 0);
    @(negedge clk);
    trip_in = 1'b0;
    chk("R8 flag set", trip_flag, 1);

    // R9: latched over a whole frame
    wait_sync();
    frame(n, h);
    chk("R9 high while latched", h, 0);
    chk("R9 flag still set", trip_flag, 1);
    trip_in = 1'b1; trip_clr = 1'b1;
    @(negedge clk);
    trip_in = 1'b0; trip_clr = 1'b0;
    @(negedge clk);
    chk("R9 trip wins over clear", trip_flag, 1);
    trip_clr = 1'b1;
    @(negedge clk);
    trip_clr = 1'b0;
    chk("R9 flag cleared", trip_flag, 0);
    wait_sync();
    frame(n, h);
    chk("R9 output restored", h, 9);

    finish_run();
  end
endmodule